// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Result Registers

This block performs 32-bit signed and unsigned multiplication and division over many clock cycles on a single shared shift-and-add/subtract datapath. A caller pulses `start_i` with an operation code and two operands. The unit raises `busy_o` while it iterates. When it finishes, it writes a 64-bit result into two architectural result registers, read on `hi_o` and `lo_o`, and pulses `done_o` for one cycle.

A multiply leaves the upper half of the product in `hi_o` and the lower half in `lo_o`. A caller can test `hi_o` to see whether the product fits in 32 bits. A divide leaves the quotient in `lo_o` and the remainder in `hi_o`. Signed operations run on operand magnitudes, and the signs are corrected in a final step. A zero divisor is found before any iteration starts. In that case the unit raises a flag and returns at once without touching the result registers.

Top module: `seq_muldiv`

## Requirements
- R1: During and right after a synchronous reset, `busy_o`, `done_o` and `div_zero_o` are 0, and `hi_o` and `lo_o` read 0.
- R2: Operation code 1 (unsigned multiply) places the 64-bit product of the two operands, both taken as unsigned, into `hi_o` (upper 32 bits) and `lo_o` (lower 32 bits).
- R3: Operation code 0 (signed multiply) places the 64-bit two's-complement product of the operands, both taken as signed, into `hi_o`/`lo_o`. The product of the most negative value with itself is included.
- R4: Operation code 3 (unsigned divide) with a non-zero divisor places the quotient of `a_i / b_i` into `lo_o` and the remainder into `hi_o`.
- R5: Operation code 2 (signed divide) with a non-zero divisor rounds the quotient toward zero into `lo_o`. The remainder goes into `hi_o` and takes the sign of the dividend. The most negative dividend over -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide (code 2 or 3) with `b_i` = 0 sets `div_zero_o`. `done_o` is high in the cycle after the accepting edge, `busy_o` never rises, and `hi_o`/`lo_o` keep their previous values.
- R7: For an operation that iterates, `busy_o` is high for exactly 33 cycles after the accepting edge. `done_o` is high for the single cycle after `busy_o` falls, and the new `hi_o`/`lo_o` are visible in that same cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation's result and timing are unchanged, and no extra result is produced.
- R9: Every accepted start that is not a zero-divisor divide clears `div_zero_o`. A multiply never sets it, even when `b_i` is 0.
- R10: `hi_o` and `lo_o` change only at the edge where `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_i | input | 2 | 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last accepted operation was a divide by zero |
| hi_o | output | 32 | Upper product half or remainder |
| lo_o | output | 32 | Lower product half or quotient |

## Verification
Each result has a fixed due time. An iterating operation completes 34 cycles after the cycle in which its start was driven: one accepting edge, 32 iteration edges and one sign-correction edge. A zero-divisor divide completes in the very next cycle. The driver writes this due cycle into each expected item, and the monitor samples on the falling edge and checks that `done_o` appears in exactly that cycle, with the expected result registers and flag. Starts issued while the unit is busy push no expected item, so any extra or shifted completion shows up as a mismatch.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;
endpackage

// File: rtl/muldiv_operand_prep.sv
module muldiv_operand_prep #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] mag_a_o,
  output logic [XLEN-1:0] mag_b_o,
  output logic            neg_a_o,
  output logic            neg_b_o
);
  import muldiv_pkg::*;

  logic is_signed;

  always_comb begin
    is_signed = (op_i == OP_MULS) || (op_i == OP_DIVS);
    neg_a_o   = is_signed && a_i[XLEN-1];
    neg_b_o   = is_signed && b_i[XLEN-1];
    mag_a_o   = neg_a_o ? (~a_i + 1'b1) : a_i;
    mag_b_o   = neg_b_o ? (~b_i + 1'b1) : b_i;
  end
endmodule

// File: rtl/muldiv_step_core.sv
module muldiv_step_core #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            step_i,
  input  logic            is_div_i,
  input  logic [XLEN-1:0] mag_a_i,
  input  logic [XLEN-1:0] mag_b_i,
  output logic [XLEN-1:0] raw_hi_o,
  output logic [XLEN-1:0] raw_lo_o
);
  localparam int AW = XLEN + 2;

  logic [XLEN:0]   acc_q;
  logic [XLEN-1:0] sh_q;
  logic [XLEN-1:0] opnd_q;

  logic [XLEN:0]   src_a;
  logic [AW-1:0]   add_a;
  logic [AW-1:0]   add_b;
  logic [AW-1:0]   sum;
  logic            below;
  logic [XLEN:0]   mul_acc;

  always_comb begin
    src_a = is_div_i ? {acc_q[XLEN-1:0], sh_q[XLEN-1]} : acc_q;
    add_a = {1'b0, src_a};
    add_b = {2'b00, opnd_q};
    sum   = add_a + (is_div_i ? ~add_b : add_b) + {{(AW-1){1'b0}}, is_div_i};
    below = sum[AW-1];
    mul_acc = sh_q[0] ? sum[XLEN:0] : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      sh_q   <= '0;
      opnd_q <= '0;
    end else if (load_i) begin
      acc_q  <= '0;
      sh_q   <= is_div_i ? mag_a_i : mag_b_i;
      opnd_q <= is_div_i ? mag_b_i : mag_a_i;
    end else if (step_i) begin
      if (is_div_i) begin
        acc_q <= below ? src_a : sum[XLEN:0];
        sh_q  <= {sh_q[XLEN-2:0], ~below};
      end else begin
        acc_q <= {1'b0, mul_acc[XLEN:1]};
        sh_q  <= {mul_acc[0], sh_q[XLEN-1:1]};
      end
    end
  end

  assign raw_hi_o = acc_q[XLEN-1:0];
  assign raw_lo_o = sh_q;
endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix #(
  parameter int XLEN = 32
) (
  input  logic            is_div_i,
  input  logic            neg_a_i,
  input  logic            neg_b_i,
  input  logic [XLEN-1:0] raw_hi_i,
  input  logic [XLEN-1:0] raw_lo_i,
  output logic [XLEN-1:0] fix_hi_o,
  output logic [XLEN-1:0] fix_lo_o
);
  logic [2*XLEN-1:0] wide;
  logic              flip;

  always_comb begin
    flip = neg_a_i ^ neg_b_i;
    wide = {raw_hi_i, raw_lo_i};
    if (is_div_i) begin
      fix_lo_o = flip    ? (~raw_lo_i + 1'b1) : raw_lo_i;
      fix_hi_o = neg_a_i ? (~raw_hi_i + 1'b1) : raw_hi_i;
    end else begin
      if (flip) wide = ~wide + 1'b1;
      fix_hi_o = wide[2*XLEN-1:XLEN];
      fix_lo_o = wide[XLEN-1:0];
    end
  end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            div_zero_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  import muldiv_pkg::*;

  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);

  md_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic            is_div_q;
  logic            neg_a_q;
  logic            neg_b_q;
  logic            busy_q;
  logic            done_q;
  logic            dz_q;
  logic [XLEN-1:0] hi_q;
  logic [XLEN-1:0] lo_q;

  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_a, neg_b;
  logic            req_div;
  logic            accept;
  logic            zero_div;
  logic            load;
  logic            step;
  logic            core_div;
  logic [XLEN-1:0] raw_hi, raw_lo;
  logic [XLEN-1:0] fix_hi, fix_lo;

  always_comb begin
    req_div  = (op_i == OP_DIVS) || (op_i == OP_DIVU);
    accept   = start_i && (state_q == ST_IDLE);
    zero_div = accept && req_div && (b_i == '0);
    load     = accept && !zero_div;
    step     = (state_q == ST_RUN);
    core_div = load ? req_div : is_div_q;
  end

  muldiv_operand_prep #(.XLEN(XLEN)) u_prep (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .neg_a_o (neg_a),
    .neg_b_o (neg_b)
  );

  muldiv_step_core #(.XLEN(XLEN)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .step_i   (step),
    .is_div_i (core_div),
    .mag_a_i  (mag_a),
    .mag_b_i  (mag_b),
    .raw_hi_o (raw_hi),
    .raw_lo_o (raw_lo)
  );

  muldiv_sign_fix #(.XLEN(XLEN)) u_fix (
    .is_div_i (is_div_q),
    .neg_a_i  (neg_a_q),
    .neg_b_i  (neg_b_q),
    .raw_hi_i (raw_hi),
    .raw_lo_i (raw_lo),
    .fix_hi_o (fix_hi),
    .fix_lo_o (fix_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      is_div_q <= 1'b0;
      neg_a_q  <= 1'b0;
      neg_b_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      dz_q     <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (zero_div) begin
            dz_q   <= 1'b1;
            done_q <= 1'b1;
          end else if (load) begin
            dz_q     <= 1'b0;
            busy_q   <= 1'b1;
            is_div_q <= req_div;
            neg_a_q  <= neg_a;
            neg_b_q  <= neg_b;
            cnt_q    <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) state_q <= ST_FIX;
        end
        ST_FIX: begin
          hi_q    <= fix_hi;
          lo_q    <= fix_lo;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign div_zero_o = dz_q;
  assign hi_o       = hi_q;
  assign lo_o       = lo_q;
endmodule

// File: rtl/seq_muldiv_chk.sv
module seq_muldiv_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic [1:0]      op_i,
  input logic [XLEN-1:0] b_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            div_zero_o,
  input logic [XLEN-1:0] hi_o,
  input logic [XLEN-1:0] lo_o
);
  localparam int LAT = XLEN + 1;
  localparam int RW  = $clog2(LAT + 2) + 1;

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R1: the cycle after reset shows an idle, clean unit
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !div_zero_o && hi_o == '0 && lo_o == '0));

  // R7: the busy window lasts exactly LAT cycles
  a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_len == RW'(LAT)));

  // R7: completion is announced as busy drops
  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R7: done never overlaps busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R10: result registers move only with done
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));

  // R6: a zero-divisor completion leaves results untouched
  a_r6_dz_keep: assert property (@(posedge clk) disable iff (rst)
    (done_o && div_zero_o) |-> ($stable(hi_o) && $stable(lo_o) && !busy_o));

  // R6: idle zero-divisor divide request completes next cycle
  a_r6_dz_fast: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && op_i[1] && b_i == '0) |=> (done_o && div_zero_o && !busy_o));

  // R9: a multiply start never raises the flag
  a_r9_mul_no_flag: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !op_i[1]) |=> !div_zero_o);
endmodule

bind seq_muldiv seq_muldiv_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .op_i       (op_i),
  .b_i        (b_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .div_zero_o (div_zero_o),
  .hi_o       (hi_o),
  .lo_o       (lo_o)
);

// File: tb/seq_muldiv_bench.sv
module seq_muldiv_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          busy_o, done_o, div_zero_o;
  logic [W-1:0]  hi_o, lo_o;

  always #2.5 clk = ~clk;

  seq_muldiv #(.XLEN(W)) u_seq_muldiv (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .div_zero_o(div_zero_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    logic         dz;
    int           due;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           cyc = 0;
  int           total = 0;
  int           bad = 0;
  logic [W-1:0] m_hi = '0;
  logic [W-1:0] m_lo = '0;
  bit           finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag,
                        input bit poke_busy);
    exp_t e;
    longint sa, sb2;
    logic [63:0] p;
    @(negedge clk);
    e.tag = tag;
    e.dz  = 1'b0;
    if (op[1] && b == '0) begin
      e.dz = 1'b1; e.hi = m_hi; e.lo = m_lo; e.due = cyc + 1;
    end else begin
      e.due = cyc + 34;
      sa  = longint'($signed(a));
      sb2 = longint'($signed(b));
      case (op)
        2'd0: begin p = 64'(sa * sb2); e.hi = p[63:32]; e.lo = p[31:0]; end
        2'd1: begin p = {32'd0, a} * {32'd0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
        2'd2: begin e.lo = 32'(sa / sb2); e.hi = 32'(sa % sb2); end
        default: begin e.lo = a / b; e.hi = a % b; end
      endcase
    end
    m_hi = e.hi; m_lo = e.lo;
    sb.push_back(e);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    if (!e.dz) check(busy_o == 1'b1, "R7", "busy after start", 64'(busy_o), 64'd1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; op_i = 2'd1; a_i = 32'h1234; b_i = 32'h0;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R8", "busy kept", 64'(busy_o), 64'd1);
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, e.tag, "done cycle", 64'(cyc), 64'(e.due));
          check(hi_o == e.hi, e.tag, "hi", 64'(hi_o), 64'(e.hi));
          check(lo_o == e.lo, e.tag, "lo", 64'(lo_o), 64'(e.lo));
          check(div_zero_o == e.dz, e.tag, "div_zero", 64'(div_zero_o), 64'(e.dz));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o && !div_zero_o, "R1", "flags in reset",
          64'({busy_o, done_o, div_zero_o}), 64'd0);
    check(hi_o == '0 && lo_o == '0, "R1", "results in reset", {hi_o, lo_o}, 64'd0);
    rst = 1'b0;

    run_op(2'd1, 32'd3, 32'd5, "R2", 0);
    run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 0);
    run_op(2'd0, -32'sd3, 32'sd7, "R3", 0);
    run_op(2'd0, 32'h8000_0000, 32'h8000_0000, "R3", 0);
    run_op(2'd0, 32'h7FFF_FFFF, -32'sd2, "R3", 0);
    run_op(2'd3, 32'd100, 32'd7, "R4", 0);
    run_op(2'd3, 32'd5, 32'd9, "R4", 0);
    run_op(2'd3, 32'hFFFF_FFFF, 32'd1, "R4", 0);
    run_op(2'd2, -32'sd7, 32'sd2, "R5", 0);
    run_op(2'd2, 32'sd7, -32'sd2, "R5", 0);
    run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R5", 0);
    run_op(2'd2, 32'sd9, 32'sd0, "R6", 0);
    run_op(2'd3, 32'd77, 32'd0, "R6", 0);
    // R9: multiply by zero clears the flag and does not set it
    run_op(2'd1, 32'd77, 32'd0, "R9", 0);
    check(div_zero_o == 1'b0, "R9", "flag after mul", 64'(div_zero_o), 64'd0);
    // R8: start during busy ignored
    run_op(2'd3, 32'd1000, 32'd3, "R8", 1);
    // R10: results hold while idle
    repeat (5) @(negedge clk);
    check(hi_o == m_hi && lo_o == m_lo, "R10", "idle hold", {hi_o, lo_o}, {m_hi, m_lo});

    repeat (40) @(negedge clk);
    check(sb.size() == 0, "R7", "all results seen", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule